// File: doc/BRIEF.md
# Start-to-End Window Monitor with Retrigger Lockout

This block watches two single-cycle strobes on one clock: an opening strobe (`start_i`) and a closing strobe (`end_i`). When an opening strobe is sampled while the monitor is idle, the monitor becomes busy and opens a timing window of `WIN_LEN` cycles. If a closing strobe is sampled inside that window, the monitor reports success. If the window runs out with no closing strobe, it reports failure. In both cases it then returns to idle.

Only one window can be open at a time. While a window is open, a further opening strobe is turned away. It does not restart or extend the window; instead it raises a separate overlap pulse, which marks a protocol error. The block can be placed next to any producer/consumer pair and checks in hardware that every request gets its answer in time.

The external reset is asynchronous and active low. Its release is synchronised inside the block, so all state leaves reset two clock edges after `rst_ni` rises.

Top module: `strobe_window_mon`

## Requirements
- R1: When `start_i` is sampled high at a clock edge while `busy_o` is low, `busy_o` reads high after that edge. That edge is cycle 0 of the window.
- R2: A closing strobe sampled at the edge ending cycle c, with 1 ≤ c ≤ `WIN_LEN` (default 5), gives one cycle of `pass_o` high after that edge. `busy_o` is low from that same edge on. Only the first such strobe counts.
- R3: A closing strobe sampled in cycle 0 (the same edge as the accepted opening strobe) does not count toward a pass.
- R4: With no qualifying closing strobe by cycle `WIN_LEN`, `fail_o` is high for one cycle after the edge ending cycle `WIN_LEN`. `busy_o` is low from that edge on.
- R5: An opening strobe sampled while `busy_o` is high gives one cycle of `overlap_o` after that edge. It neither restarts nor extends the open window.
- R6: A closing strobe sampled while idle has no effect: no pass, no fail, and `busy_o` stays low.
- R7: `pass_o` and `fail_o` are never high together. `overlap_o` can coincide with either of them when the opening strobe arrives at the edge that ends the window.
- R8: While `rst_ni` is low, `busy_o`, `pass_o`, `fail_o` and `overlap_o` are all low. This holds even when reset is applied in the middle of an open window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Opening strobe |
| end_i | input | 1 | Closing strobe |
| busy_o | output | 1 | High while a window is open |
| pass_o | output | 1 | One-cycle pulse: closing strobe arrived inside the window |
| fail_o | output | 1 | One-cycle pulse: window expired with no closing strobe |
| overlap_o | output | 1 | One-cycle pulse: opening strobe arrived while busy |

## Verification
A verdict and an overlap can fall in the same cycle. This happens when a second opening strobe lands on the very edge that closes the window, either together with the closing strobe (pass plus overlap) or on the expiry edge (fail plus overlap). The sweep places the retrigger at every cycle of the window, for every position of the closing strobe. In each case it requires both pulses to appear after the same edge. It also requires `busy_o` to stay low afterwards, because the turned-away strobe must not have opened a new window.

// File: rtl/win_pkg.sv
package win_pkg;

  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_OPEN = 1'b1
  } win_state_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/win_rst_sync.sv
module win_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/win_timer.sv
module win_timer #(
  parameter int unsigned WIN_LEN = 5,
  parameter int unsigned CNT_W   = win_pkg::cnt_width(WIN_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic adv_i,
  output logic expire_o
);

  localparam logic [CNT_W-1:0] LimitVal = CNT_W'(WIN_LEN);
  localparam logic [CNT_W-1:0] FirstVal = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | adv_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = FirstVal;
    else if (adv_i) cnt_d = cnt_q + FirstVal;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == LimitVal);

  // R4
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LimitVal);

  // R4
  adv_below_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> !expire_o);

endmodule

// File: rtl/win_ctrl.sv
module win_ctrl
  import win_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic end_i,
  input  logic expire_i,
  output logic load_o,
  output logic adv_o,
  output logic busy_o,
  output logic pass_o,
  output logic fail_o,
  output logic overlap_o
);

  win_state_e state_q, state_d;
  logic pass_q, pass_d, fail_q, fail_d, ovl_q, ovl_d;

  always_comb begin
    state_d = state_q;
    pass_d  = 1'b0;
    fail_d  = 1'b0;
    ovl_d   = 1'b0;
    load_o  = 1'b0;
    adv_o   = 1'b0;
    unique case (state_q)
      WS_IDLE: begin
        if (start_i) begin
          state_d = WS_OPEN;
          load_o  = 1'b1;
        end
      end
      WS_OPEN: begin
        ovl_d = start_i;
        if (end_i) begin
          pass_d  = 1'b1;
          state_d = WS_IDLE;
        end else if (expire_i) begin
          fail_d  = 1'b1;
          state_d = WS_IDLE;
        end else begin
          adv_o = 1'b1;
        end
      end
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      ovl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
      ovl_q   <= ovl_d;
    end
  end

  assign busy_o    = (state_q == WS_OPEN);
  assign pass_o    = pass_q;
  assign fail_o    = fail_q;
  assign overlap_o = ovl_q;

  // R1
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R2
  pass_needs_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> ($past(end_i) && $past(busy_o) && !busy_o));

  // R4
  fail_clears_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (!busy_o && $past(busy_o) && !$past(end_i)));

  // R5
  overlap_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overlap_o |-> ($past(busy_o) && $past(start_i)));

  // R6
  idle_end_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && end_i && !start_i) |=> (!pass_o && !busy_o));

  // R7
  verdict_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));

endmodule

// File: rtl/strobe_window_mon.sv
module strobe_window_mon #(
  parameter int unsigned WIN_LEN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic end_i,
  output logic busy_o,
  output logic pass_o,
  output logic fail_o,
  output logic overlap_o
);

  localparam int unsigned CntW = win_pkg::cnt_width(WIN_LEN);

  logic rst_sync_n;
  logic load, adv, expire;

  win_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  win_timer #(.WIN_LEN(WIN_LEN), .CNT_W(CntW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .load_i   (load),
    .adv_i    (adv),
    .expire_o (expire)
  );

  win_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .start_i   (start_i),
    .end_i     (end_i),
    .expire_i  (expire),
    .load_o    (load),
    .adv_o     (adv),
    .busy_o    (busy_o),
    .pass_o    (pass_o),
    .fail_o    (fail_o),
    .overlap_o (overlap_o)
  );

endmodule

// File: tb/test_strobe_window_mon.sv
`timescale 1ns/1ps
module test_strobe_window_mon;

  localparam int WIN = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic stop = 1'b0;
  logic busy, pass, fail, ovl;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  strobe_window_mon #(.WIN_LEN(WIN)) i_strobe_window_mon (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .end_i     (stop),
    .busy_o    (busy),
    .pass_o    (pass),
    .fail_o    (fail),
    .overlap_o (ovl)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic reset_all();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; stop = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", "busy in reset", busy, 1'b0);
    check("R8", "pass in reset", pass, 1'b0);
    check("R8", "fail in reset", fail, 1'b0);
    check("R8", "overlap in reset", ovl, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // d: cycle of closing strobe (-1 none); s: cycle of retrigger (-1 none)
  task automatic run_case(input int d, input int s);
    bit dpass;
    int fin;
    string ptag;
    dpass = (d >= 1 && d <= WIN);
    fin   = dpass ? d : WIN;
    ptag  = (d == 0) ? "R3" : ((d > WIN) ? "R6" : "R2");
    for (int c = 0; c <= WIN + 3; c++) begin
      @(negedge clk);
      start = (c == 0) || (c == s);
      stop  = (c == d);
      @(posedge clk);
      #1;
      check("R1", "busy", busy, (c < fin));
      check(ptag, "pass", pass, (dpass && c == d));
      check("R4", "fail", fail, (!dpass && c == WIN));
      check((s == fin) ? "R7" : "R5", "overlap", ovl, (s >= 1 && s <= fin && c == s));
    end
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    reset_all();
    // R6: closing strobe while idle
    @(negedge clk); stop = 1'b1;
    @(posedge clk); #1;
    check("R6", "busy after idle end", busy, 1'b0);
    @(negedge clk); stop = 1'b0;
    @(posedge clk); #1;
    check("R6", "pass after idle end", pass, 1'b0);

    for (int d = -1; d <= WIN + 2; d++) begin
      for (int s = -1; s <= WIN; s++) begin
        if (s == 0) continue;
        if (s > ((d >= 1 && d <= WIN) ? d : WIN)) continue;
        run_case(d, s);
      end
    end

    // R8: reset in the middle of an open window
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check("R1", "busy before mid reset", busy, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R8", "busy after mid reset", busy, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R8", "fail after mid reset", fail, 1'b0);
    check("R8", "busy stays low", busy, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule